// File: doc/BRIEF.md
# Split-Byte Double-Buffered Converter Register Front End

This block is the digital side of a 12-bit voltage-output converter that is fed from an 8-bit parallel bus. A host writes the code in two bytes. A byte-select line decides whether a write fills the lower eight code bits or the upper four. The upper byte also carries two control bits, one for the reference buffer and one for the output range. Writes land in an input register. A separate transfer strobe copies that register into the converter register, which drives the code outputs. Because of this double buffering, a multi-byte update reaches the converter in a single step, and several converters can be updated together.

All bus and strobe inputs come from an asynchronous host. They pass through a synchroniser chain before any decision is made, and the end of a write strobe is found by edge detection in the clock domain. A clear input zeroes both registers. A power-down input drops the output-enable flag that controls the three-state output stage. Leaving power-down takes a fixed, parameterised number of cycles before the output is enabled again.

The power controller has three states. `PW_ACTIVE` moves to `PW_ASLEEP` when power-down is requested. `PW_ASLEEP` moves to `PW_WAKING` when the request is released. `PW_WAKING` moves back to `PW_ASLEEP` if the request returns, and to `PW_ACTIVE` once `WAKE_CYCLES` cycles have passed. The register bank decodes one action per cycle, in this priority order: `ACT_CLEAR`, `ACT_LOAD_XFER` (write with transfer strobe), `ACT_LOAD` (write only), `ACT_XFER` (transfer only) and `ACT_IDLE`.

Top module: `pdac_front`

## Requirements
- R1: A write occurs only when the synchronised `wr_n` goes from 0 to 1 while the synchronised `cs_n` is 0. When `cs_n` is high, or when `wr_n` stays high, the input register does not change.
- R2: A write with `hben`=0 places `db[7:0]` into code bits 7:0 of the input register and leaves bits 11:8 unchanged.
- R3: A write with `hben`=1 places `db[3:0]` into code bits 11:8 and leaves bits 7:0 unchanged.
- R4: A write with `hben`=1 takes `db[4]` as the reference-buffer enable and `db[5]` as the gain select (1 = double range). `db[7:6]` have no effect. These control bits reach `ref_buf_en` and `gain_2x` through the same transfer path as the code.
- R5: If `ldac_n` is 0 during a write, the converter register receives the newly merged input register value.
- R6: If `ldac_n` is 0 with no write in that cycle, the input register is copied to the converter register whatever `cs_n` and `wr_n` are. Without such a transfer, the outputs keep their values.
- R7: If `clr_n` is 0, both registers and both control bits are zeroed. This takes priority over a write or a transfer in the same cycle.
- R8: After reset, `dac_code`=0, `ref_buf_en`=0, `gain_2x`=0 and `out_en`=1.
- R9: While `pd_n` is 0, `out_en` is 0. Register contents are kept, and writes and transfers still take effect.
- R10: After `pd_n` returns to 1, `out_en` asserts on the (WAKE_CYCLES+3)-th rising clock edge. A new power-down request during the wait restarts it.
- R11: An input change sampled at a clock edge shows at the outputs after the third edge, counting that edge: two synchroniser flops plus the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Write strobe, active low, acts on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| ldac_n | input | 1 | Transfer strobe, active low |
| clr_n | input | 1 | Clear, active low |
| hben | input | 1 | Byte select: 1 = upper byte |
| pd_n | input | 1 | Power-down request, active low |
| db | input | 8 | Parallel data bus |
| dac_code | output | 12 | Converter register code |
| ref_buf_en | output | 1 | Reference buffer enable |
| gain_2x | output | 1 | Output range select, 1 = double range |
| out_en | output | 1 | Output stage enable (0 = high impedance) |

## Verification
Split writes are tried with the upper and lower bytes held apart by a separate transfer pulse. This distinguishes a correctly staged input register from one that passes data straight through. Writes are also tried with the transfer strobe held low during the write, writes with chip select high, and a chip select with no strobe edge; these separate a qualified write from a bare level. A clear that coincides with a write and a transfer checks the priority order. Power-down entry, exit and a request that interrupts a wake-up check the wake timer. A behavioural model compares all outputs on every cycle.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

    localparam int REFBUF_BIT = 4;
    localparam int GAIN_BIT   = 5;

    typedef struct packed {
        logic wr_n;
        logic cs_n;
        logic ldac_n;
        logic clr_n;
        logic hben;
        logic pd_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{wr_n: 1'b1, cs_n: 1'b1, ldac_n: 1'b1,
                                  clr_n: 1'b1, hben: 1'b0, pd_n: 1'b1};

    typedef enum logic [1:0] {
        PW_ACTIVE = 2'd0,
        PW_ASLEEP = 2'd1,
        PW_WAKING = 2'd2
    } pwr_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE      = 3'd0,
        ACT_CLEAR     = 3'd1,
        ACT_LOAD      = 3'd2,
        ACT_LOAD_XFER = 3'd3,
        ACT_XFER      = 3'd4
    } reg_act_e;

endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= IDLE;
            end else if (g == 0) begin
                chain[g] <= d_async;
            end else begin
                chain[g] <= chain[(g > 0) ? g - 1 : 0];
            end
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/pdac_regs.sv
module pdac_regs
    import pdac_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus,
    input  logic              hi_sel,
    input  logic              wr_evt,
    input  logic              xfer_req,
    input  logic              clr_req,
    output logic [CODE_W-1:0] dac_code,
    output logic              ref_buf_en,
    output logic              gain_2x
);

    localparam int HI_W = CODE_W - BUS_W;

    reg_act_e          act;
    logic [CODE_W-1:0] in_code, in_code_nxt, ld_code, dac_nxt;
    logic              in_ref, in_ref_nxt, ld_ref, ref_nxt;
    logic              in_gain, in_gain_nxt, ld_gain, gain_nxt;
    logic              spare_unused;

    assign spare_unused = ^bus[BUS_W-1:GAIN_BIT+1];

    // action decode, clear first
    always_comb begin
        if (clr_req) begin
            act = ACT_CLEAR;
        end else if (wr_evt && xfer_req) begin
            act = ACT_LOAD_XFER;
        end else if (wr_evt) begin
            act = ACT_LOAD;
        end else if (xfer_req) begin
            act = ACT_XFER;
        end else begin
            act = ACT_IDLE;
        end
    end

    // merged value the input register would take on a write
    always_comb begin
        if (hi_sel) begin
            ld_code = {bus[HI_W-1:0], in_code[BUS_W-1:0]};
            ld_ref  = bus[REFBUF_BIT];
            ld_gain = bus[GAIN_BIT];
        end else begin
            ld_code = {in_code[CODE_W-1:BUS_W], bus};
            ld_ref  = in_ref;
            ld_gain = in_gain;
        end
    end

    always_comb begin
        in_code_nxt = in_code;
        in_ref_nxt  = in_ref;
        in_gain_nxt = in_gain;
        dac_nxt     = dac_code;
        ref_nxt     = ref_buf_en;
        gain_nxt    = gain_2x;
        unique case (act)
            ACT_CLEAR: begin
                in_code_nxt = '0;
                in_ref_nxt  = 1'b0;
                in_gain_nxt = 1'b0;
                dac_nxt     = '0;
                ref_nxt     = 1'b0;
                gain_nxt    = 1'b0;
            end
            ACT_LOAD: begin
                in_code_nxt = ld_code;
                in_ref_nxt  = ld_ref;
                in_gain_nxt = ld_gain;
            end
            ACT_LOAD_XFER: begin
                in_code_nxt = ld_code;
                in_ref_nxt  = ld_ref;
                in_gain_nxt = ld_gain;
                dac_nxt     = ld_code;
                ref_nxt     = ld_ref;
                gain_nxt    = ld_gain;
            end
            ACT_XFER: begin
                dac_nxt  = in_code;
                ref_nxt  = in_ref;
                gain_nxt = in_gain;
            end
            ACT_IDLE: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_code    <= '0;
            in_ref     <= 1'b0;
            in_gain    <= 1'b0;
            dac_code   <= '0;
            ref_buf_en <= 1'b0;
            gain_2x    <= 1'b0;
        end else begin
            in_code    <= in_code_nxt;
            in_ref     <= in_ref_nxt;
            in_gain    <= in_gain_nxt;
            dac_code   <= dac_nxt;
            ref_buf_en <= ref_nxt;
            gain_2x    <= gain_nxt;
        end
    end

endmodule

// File: rtl/pdac_pwr.sv
module pdac_pwr
    import pdac_pkg::*;
#(
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    output logic out_en
);

    localparam int CNT_W = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

    pwr_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            PW_ACTIVE: begin
                if (pd_req) state_nxt = PW_ASLEEP;
            end
            PW_ASLEEP: begin
                if (!pd_req) begin
                    state_nxt = PW_WAKING;
                    cnt_nxt   = '0;
                end
            end
            PW_WAKING: begin
                if (pd_req) begin
                    state_nxt = PW_ASLEEP;
                end else if (cnt == CNT_LAST) begin
                    state_nxt = PW_ACTIVE;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: state_nxt = PW_ASLEEP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_ACTIVE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_en <= 1'b1;
        end else begin
            out_en <= (state_nxt == PW_ACTIVE);
        end
    end

endmodule

// File: rtl/pdac_front.sv
module pdac_front
    import pdac_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              hben,
    input  logic              pd_n,
    input  logic [BUS_W-1:0]  db,
    output logic [CODE_W-1:0] dac_code,
    output logic              ref_buf_en,
    output logic              gain_2x,
    output logic              out_en
);

    localparam int CTL_W  = $bits(ctl_t);
    localparam int SYNC_W = CTL_W + BUS_W;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = {CTL_IDLE, {BUS_W{1'b0}}};

    ctl_t              ctl_raw, ctl_s;
    logic [BUS_W-1:0]  db_s;
    logic              wr_prev;
    logic              wr_evt;

    assign ctl_raw = '{wr_n: wr_n, cs_n: cs_n, ldac_n: ldac_n,
                       clr_n: clr_n, hben: hben, pd_n: pd_n};

    pdac_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ctl_raw, db}),
        .d_sync  ({ctl_s, db_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= ctl_s.wr_n;
    end

    assign wr_evt = !wr_prev && ctl_s.wr_n && !ctl_s.cs_n;

    pdac_regs #(
        .CODE_W (CODE_W),
        .BUS_W  (BUS_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus        (db_s),
        .hi_sel     (ctl_s.hben),
        .wr_evt     (wr_evt),
        .xfer_req   (!ctl_s.ldac_n),
        .clr_req    (!ctl_s.clr_n),
        .dac_code   (dac_code),
        .ref_buf_en (ref_buf_en),
        .gain_2x    (gain_2x)
    );

    pdac_pwr #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pd_req (!ctl_s.pd_n),
        .out_en (out_en)
    );

endmodule

// File: rtl/pdac_chk.sv
module pdac_chk #(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ldac_n,
    input logic              clr_n,
    input logic              pd_n,
    input logic [CODE_W-1:0] dac_code,
    input logic              ref_buf_en,
    input logic              gain_2x,
    input logic              out_en
);

    localparam int LAT    = SYNC_STAGES + 1;
    localparam int HR_MAX = WAKE_CYCLES + LAT;
    localparam int HR_W   = $clog2(HR_MAX + 1);

    logic [3:0]      since_rst;
    logic [HR_W-1:0] hi_run;
    logic            warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            hi_run    <= '0;
        end else begin
            if (since_rst != 4'hF) since_rst <= since_rst + 1'b1;
            if (!pd_n)                         hi_run <= '0;
            else if (hi_run != HR_W'(HR_MAX))  hi_run <= hi_run + 1'b1;
        end
    end

    assign warm = (since_rst >= 4'(LAT));

    AST_PD_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(pd_n, LAT)) |-> !out_en); // R9

    AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> (hi_run >= HR_W'(HR_MAX))); // R10

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(clr_n, LAT)) |-> (dac_code == '0 && !ref_buf_en && !gain_2x)); // R7

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(ldac_n, LAT) && $past(clr_n, LAT)) |-> $stable(dac_code)); // R6

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(ldac_n, LAT) && $past(clr_n, LAT)) |-> ($stable(ref_buf_en) && $stable(gain_2x))); // R4

endmodule

bind pdac_front pdac_chk #(
    .CODE_W      (CODE_W),
    .SYNC_STAGES (SYNC_STAGES),
    .WAKE_CYCLES (WAKE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ldac_n     (ldac_n),
    .clr_n      (clr_n),
    .pd_n       (pd_n),
    .dac_code   (dac_code),
    .ref_buf_en (ref_buf_en),
    .gain_2x    (gain_2x),
    .out_en     (out_en)
);

// File: tb/pdac_front_test.sv
module pdac_front_test;

    localparam int CLK_NS = 10;
    localparam int WAKE   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1, cs_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
    logic        hben = 1'b0, pd_n = 1'b1;
    logic [7:0]  db = 8'h00;
    logic [11:0] dac_code;
    logic        ref_buf_en, gain_2x, out_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    pdac_front #(.WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_n(cs_n), .ldac_n(ldac_n),
        .clr_n(clr_n), .hben(hben), .pd_n(pd_n), .db(db),
        .dac_code(dac_code), .ref_buf_en(ref_buf_en), .gain_2x(gain_2x), .out_en(out_en)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct {
        bit wr_n, cs_n, ldac_n, clr_n, hben, pd_n;
        int db;
    } smp_t;

    smp_t hist[$];
    int   m_in, m_iref, m_igain, m_code, m_ref, m_gain, m_oe;
    int   m_pst, m_left;   // 0 on, 1 asleep, 2 waking

    function automatic smp_t idle_smp();
        smp_t s;
        s.wr_n = 1; s.cs_n = 1; s.ldac_n = 1; s.clr_n = 1; s.hben = 0; s.pd_n = 1; s.db = 0;
        return s;
    endfunction

    always @(posedge clk) begin
        smp_t cur, s, p;
        bit   wev;
        cur.wr_n = wr_n; cur.cs_n = cs_n; cur.ldac_n = ldac_n; cur.clr_n = clr_n;
        cur.hben = hben; cur.pd_n = pd_n; cur.db = int'(db);
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 4; i++) hist.push_back(idle_smp());
            m_in = 0; m_iref = 0; m_igain = 0; m_code = 0; m_ref = 0; m_gain = 0;
            m_oe = 1; m_pst = 0; m_left = 0;
        end else begin
            hist.push_front(cur);
            while (hist.size() > 4) void'(hist.pop_back());
            s = hist[2];
            p = hist[3];
            wev = !p.wr_n && s.wr_n && !s.cs_n;
            if (!s.clr_n) begin
                m_in = 0; m_iref = 0; m_igain = 0; m_code = 0; m_ref = 0; m_gain = 0;
            end else begin
                if (wev) begin
                    if (s.hben) begin
                        m_in    = (m_in & 'hFF) | ((s.db & 'hF) << 8);
                        m_iref  = (s.db >> 4) & 1;
                        m_igain = (s.db >> 5) & 1;
                    end else begin
                        m_in = (m_in & 'hF00) | (s.db & 'hFF);
                    end
                end
                if (!s.ldac_n) begin
                    m_code = m_in; m_ref = m_iref; m_gain = m_igain;
                end
            end
            case (m_pst)
                0: if (!s.pd_n) begin m_pst = 1; m_oe = 0; end
                1: if (s.pd_n) begin m_pst = 2; m_left = WAKE; end
                default: begin
                    if (!s.pd_n) m_pst = 1;
                    else begin
                        m_left--;
                        if (m_left == 0) begin m_pst = 0; m_oe = 1; end
                    end
                end
            endcase
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    bit model_on = 0;
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk("R11 model code", int'(dac_code), m_code);
            chk("R4 model refbuf", int'(ref_buf_en), m_ref);
            chk("R4 model gain", int'(gain_2x), m_gain);
            chk("R10 model out_en", int'(out_en), m_oe);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(bit hi, bit [7:0] d, bit with_ldac, bit sel);
        @(negedge clk);
        cs_n = !sel; hben = hi; db = d; wr_n = 1'b0;
        if (with_ldac) ldac_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; ldac_n = 1'b1;
        idle(4);
    endtask

    task automatic ldac_pulse();
        @(negedge clk); ldac_n = 1'b0;
        @(negedge clk); ldac_n = 1'b1;
        idle(4);
    endtask

    bit done = 0;

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        // R8: reset state
        chk("R8 code", int'(dac_code), 0);
        chk("R8 refbuf", int'(ref_buf_en), 0);
        chk("R8 gain", int'(gain_2x), 0);
        chk("R8 out_en", int'(out_en), 1);

        // R6: writes stay in the input register until transfer
        wr_byte(1'b0, 8'hA5, 1'b0, 1'b1);
        chk("R6 held low byte", int'(dac_code), 0);
        wr_byte(1'b1, 8'h23, 1'b0, 1'b1);
        chk("R6 held high byte", int'(dac_code), 0);

        // R11: transfer appears on the third edge
        @(negedge clk); ldac_n = 1'b0;
        @(negedge clk); ldac_n = 1'b1;
        @(negedge clk);
        chk("R11 two edges", int'(dac_code), 0);
        @(negedge clk);
        chk("R11 three edges", int'(dac_code), 'h3A5);
        idle(3);
        chk("R2 R3 merged code", int'(dac_code), 'h3A5);
        chk("R4 gain bit5", int'(gain_2x), 1);
        chk("R4 refbuf bit4", int'(ref_buf_en), 0);

        // R1: write strobe without chip select
        wr_byte(1'b0, 8'hFF, 1'b0, 1'b0);
        ldac_pulse();
        chk("R1 cs high ignored", int'(dac_code), 'h3A5);

        // R1: chip select without strobe edge
        @(negedge clk); cs_n = 1'b0; db = 8'h11; hben = 1'b0;
        idle(4);
        cs_n = 1'b1;
        ldac_pulse();
        chk("R1 no edge ignored", int'(dac_code), 'h3A5);

        // R5 + R4: high write with transfer low, bits 7:6 ignored
        wr_byte(1'b1, 8'hD7, 1'b1, 1'b1);
        chk("R5 code", int'(dac_code), 'h7A5);
        chk("R4 refbuf set", int'(ref_buf_en), 1);
        chk("R4 gain clear", int'(gain_2x), 0);

        // R7: clear beats simultaneous write and transfer
        @(negedge clk);
        clr_n = 1'b0; cs_n = 1'b0; hben = 1'b0; db = 8'h66; ldac_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); clr_n = 1'b1; cs_n = 1'b1; ldac_n = 1'b1;
        idle(4);
        chk("R7 code", int'(dac_code), 0);
        chk("R7 refbuf", int'(ref_buf_en), 0);
        ldac_pulse();
        chk("R7 input cleared", int'(dac_code), 0);

        // R9: power-down
        @(negedge clk); pd_n = 1'b0;
        idle(4);
        chk("R9 out_en low", int'(out_en), 0);
        wr_byte(1'b0, 8'h5C, 1'b1, 1'b1);
        chk("R9 regs active", int'(dac_code), 'h05C);
        chk("R9 still off", int'(out_en), 0);

        // R10: wake delay
        @(negedge clk); pd_n = 1'b1;
        n = 0;
        while (!out_en && n < 100) begin @(negedge clk); n++; end
        chk("R10 wake edges", n, WAKE + 3);
        chk("R9 kept code", int'(dac_code), 'h05C);

        // R10: interrupted wake restarts
        @(negedge clk); pd_n = 1'b0;
        idle(4);
        pd_n = 1'b1;
        idle(5);
        pd_n = 1'b0;
        @(negedge clk); pd_n = 1'b1;
        n = 0;
        while (!out_en && n < 100) begin @(negedge clk); n++; end
        chk("R10 restart edges", n, WAKE + 3);

        idle(5);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule